// File: doc/BRIEF.md
# Rewindable FIFO Buffer

A first-in first-out buffer with a write port and a read port on one clock. Each port is gated by an active-low enable and an active-low select, and a transfer happens only when both are low. The read side can also rewind. A retransmit pulse moves the read position back so that stored words can be delivered a second time. The write side is left as it is. Without a mark, the rewind goes to the first word written since reset. If a mark was taken, it goes to the marked word.

The read side runs in one of two styles, chosen by a static select input that may only change while reset is held. In standard style, a read request moves the oldest word into the output register, and a flag reports whether data is available. In fall-through style, the oldest word appears on the output without a request, and a ready flag reports whether the shown word is valid. A read request then consumes that word. The storage is a power-of-two array built for block RAM. The pointers carry one extra wrap bit.

Top module: `rexmit_fifo`

## Requirements
- R1: A word is stored on a rising clock edge only when `wr_en_n` and `wr_cs_n` are both low. Words leave in the order they were stored.
- R2: `full` is high exactly when DEPTH words are held in the storage array. In fall-through style, the word already shown on the output is not counted. A write request while `full` is high is dropped.
- R3: In standard style (`fwft_sel` = 0), a read request (`rd_en_n` and `rd_cs_n` both low) with data available puts the oldest word on `rd_data` after that edge. `rd_flag` high means data is available; low means empty.
- R4: A read request while the buffer is empty has no effect, and `rd_data` keeps its value.
- R5: While `rd_cs_n` is high, read requests are ignored.
- R6: Retransmit with no mark taken since reset moves the read position to the first word written after reset. This is defined while no more than DEPTH words have been written since reset.
- R7: `mark` records the next word a read will deliver. In fall-through style, that is the word currently shown. A later retransmit resumes from that word.
- R8: After a retransmit edge in standard style, `rd_flag` is low for one cycle and then follows the stored level. In fall-through style, `rd_flag` goes high (not ready), and the rewound word is shown one cycle later with `rd_flag` low.
- R9: Retransmit leaves the write position unchanged. The fill level and `full` are recomputed from the new read position.
- R10: In fall-through style (`fwft_sel` = 1), a word stored into an empty buffer is shown on `rd_data` with `rd_flag` low one cycle after the write edge. A read request advances to the next word.
- R11: A synchronous reset clears both positions, the mark and the output state. `full` goes low. `rd_flag` goes low in standard style and high in fall-through style.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fwft_sel | input | 1 | Read style: 0 standard, 1 fall-through (static) |
| wr_en_n | input | 1 | Write enable, active low |
| wr_cs_n | input | 1 | Write select, active low |
| wr_data | input | DW | Write data |
| rd_en_n | input | 1 | Read enable, active low |
| rd_cs_n | input | 1 | Read select, active low |
| mark | input | 1 | Record the current read position |
| rexmit | input | 1 | Rewind the read position |
| rd_data | output | DW | Read data register |
| rd_flag | output | 1 | Standard: 1 = data available; fall-through: 0 = word valid |
| full | output | 1 | Storage array full |

## Verification
The basic path is tried with a vector table of single writes, combined write-and-read cycles and drains. This separates correct ordering from off-by-one pointer errors and from reads that ignore the empty state. A fill past capacity followed by a full drain shows whether the extra word was dropped. A rewind after that drain shows whether the level is recomputed to full. Retransmit is tried both with and without a prior mark, and in both read styles. This separates a rewind to zero from a rewind to the mark, and confirms that the mark in fall-through style points at the word being shown rather than at the next one fetched. Select-only and enable-only patterns show that each gate blocks its port on its own.

// File: rtl/rexmit_fifo_pkg.sv
package rexmit_fifo_pkg;
  typedef enum logic {
    STYLE_STD  = 1'b0,
    STYLE_FWFT = 1'b1
  } rd_style_e;
endpackage

// File: rtl/rexmit_fifo_ram.sv
module rexmit_fifo_ram #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  // Reset-free write and registered read so the array maps to block RAM.
  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/rexmit_fifo_wptr.sv
module rexmit_fifo_wptr #(
  parameter int AW = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_req,
  input  logic        full,
  output logic        wr_fire,
  output logic [AW:0] wptr
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] ONE = PW'(1);

  assign wr_fire = wr_req & ~full;

  always_ff @(posedge clk) begin
    if (rst)          wptr <= '0;
    else if (wr_fire) wptr <= wptr + ONE;
  end
endmodule

// File: rtl/rexmit_fifo_rptr.sv
module rexmit_fifo_rptr
  import rexmit_fifo_pkg::*;
#(
  parameter int AW = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  rd_style_e   style,
  input  logic        rd_req,
  input  logic        mark,
  input  logic        rexmit,
  input  logic [AW:0] wptr,
  output logic [AW:0] rptr,
  output logic [AW:0] level,
  output logic        rd_fire,
  output logic        out_valid,
  output logic        hold
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] ONE = PW'(1);

  logic [PW-1:0] mark_q;
  logic          mark_vld_q;
  logic          have;
  logic          accept;
  logic [PW-1:0] mark_pos;
  logic          is_fwft;

  assign is_fwft = (style == STYLE_FWFT);
  assign level   = wptr - rptr;
  assign have    = (level != '0);
  assign accept  = rd_req & out_valid;

  // In fall-through style the shown word sits one behind the fetch position.
  assign mark_pos = (is_fwft && out_valid) ? (rptr - ONE) : rptr;

  always_comb begin
    if (is_fwft) rd_fire = ~rexmit & have & (~out_valid | accept);
    else         rd_fire = ~rexmit & have & ~hold & rd_req;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rptr       <= '0;
      mark_q     <= '0;
      mark_vld_q <= 1'b0;
      out_valid  <= 1'b0;
      hold       <= 1'b0;
    end else begin
      hold <= rexmit & ~is_fwft;
      if (mark) begin
        mark_q     <= mark_pos;
        mark_vld_q <= 1'b1;
      end
      if (rexmit) begin
        rptr      <= mark_vld_q ? mark_q : '0;
        out_valid <= 1'b0;
      end else begin
        if (rd_fire) rptr <= rptr + ONE;
        out_valid <= is_fwft & (rd_fire | (out_valid & ~accept));
      end
    end
  end
endmodule

// File: rtl/rexmit_fifo.sv
module rexmit_fifo
  import rexmit_fifo_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fwft_sel,
  input  logic          wr_en_n,
  input  logic          wr_cs_n,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en_n,
  input  logic          rd_cs_n,
  input  logic          mark,
  input  logic          rexmit,
  output logic [DW-1:0] rd_data,
  output logic          rd_flag,
  output logic          full
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam logic [PW-1:0] DEPTH_L = PW'(DEPTH);

  rd_style_e     style;
  logic [PW-1:0] wptr;
  logic [PW-1:0] rptr;
  logic [PW-1:0] level;
  logic          wr_fire;
  logic          rd_fire;
  logic          out_valid;
  logic          hold;

  assign style = rd_style_e'(fwft_sel);
  assign full  = (level == DEPTH_L);

  always_comb begin
    if (style == STYLE_FWFT) rd_flag = ~out_valid;
    else                     rd_flag = (level != '0) & ~hold;
  end

  rexmit_fifo_wptr #(.AW(AW)) u_wptr (
    .clk     (clk),
    .rst     (rst),
    .wr_req  (~wr_en_n & ~wr_cs_n),
    .full    (full),
    .wr_fire (wr_fire),
    .wptr    (wptr)
  );

  rexmit_fifo_rptr #(.AW(AW)) u_rptr (
    .clk       (clk),
    .rst       (rst),
    .style     (style),
    .rd_req    (~rd_en_n & ~rd_cs_n),
    .mark      (mark),
    .rexmit    (rexmit),
    .wptr      (wptr),
    .rptr      (rptr),
    .level     (level),
    .rd_fire   (rd_fire),
    .out_valid (out_valid),
    .hold      (hold)
  );

  rexmit_fifo_ram #(.DW(DW), .AW(AW)) u_ram (
    .clk   (clk),
    .we    (wr_fire),
    .waddr (wptr[AW-1:0]),
    .wdata (wr_data),
    .re    (rd_fire),
    .raddr (rptr[AW-1:0]),
    .rdata (rd_data)
  );
endmodule

// File: rtl/rexmit_fifo_chk.sv
module rexmit_fifo_chk #(
  parameter int AW = 3
) (
  input logic        clk,
  input logic        rst,
  input logic        fwft_sel,
  input logic        wr_en_n,
  input logic        wr_cs_n,
  input logic        rd_en_n,
  input logic        rd_cs_n,
  input logic        rexmit,
  input logic        rd_flag,
  input logic        full,
  input logic [AW:0] wptr,
  input logic [AW:0] rptr
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] DEPTH_L = PW'(1 << AW);

  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  assert_wr_gate_R1: assert property (@(posedge clk) disable iff (rst)
    (wr_en_n | wr_cs_n) |=> $stable(wptr));

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
    (full & ~wr_en_n & ~wr_cs_n) |=> $stable(wptr));

  assert_level_bound_R2: assert property (@(posedge clk) disable iff (rst)
    ((wptr - rptr) <= DEPTH_L));

  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (rst)
    (~fwft_sel & ~rd_flag & ~rd_en_n & ~rd_cs_n & ~rexmit) |=> $stable(rptr));

  assert_rd_select_R5: assert property (@(posedge clk) disable iff (rst)
    (~fwft_sel & rd_cs_n & ~rexmit) |=> $stable(rptr));

  assert_rexmit_std_flag_R8: assert property (@(posedge clk) disable iff (rst)
    (~fwft_sel & rexmit) |=> ~rd_flag);

  assert_rexmit_fwft_flag_R8: assert property (@(posedge clk) disable iff (rst)
    (fwft_sel & rexmit) |=> rd_flag);

  assert_rexmit_wptr_R9: assert property (@(posedge clk) disable iff (rst)
    (rexmit & (wr_en_n | wr_cs_n)) |=> $stable(wptr));

  always_ff @(posedge clk) begin
    if (rst_q === 1'b1) begin
      assert_reset_R11: assert ((wptr == rptr) && !full);
    end
  end
endmodule

bind rexmit_fifo rexmit_fifo_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .fwft_sel (fwft_sel),
  .wr_en_n  (wr_en_n),
  .wr_cs_n  (wr_cs_n),
  .rd_en_n  (rd_en_n),
  .rd_cs_n  (rd_cs_n),
  .rexmit   (rexmit),
  .rd_flag  (rd_flag),
  .full     (full),
  .wptr     (wptr),
  .rptr     (rptr)
);

// File: tb/tb_rexmit_fifo.sv
module tb_rexmit_fifo;
  localparam int DW = 8;
  localparam int AW = 3;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          fwft_sel = 1'b0;
  logic          wr_en_n = 1'b1;
  logic          wr_cs_n = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          rd_en_n = 1'b1;
  logic          rd_cs_n = 1'b0;
  logic          mark = 1'b0;
  logic          rexmit = 1'b0;
  logic [DW-1:0] rd_data;
  logic          rd_flag;
  logic          full;

  int n_checks = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  rexmit_fifo #(.DW(DW), .AW(AW)) dut (
    .clk(clk), .rst(rst), .fwft_sel(fwft_sel),
    .wr_en_n(wr_en_n), .wr_cs_n(wr_cs_n), .wr_data(wr_data),
    .rd_en_n(rd_en_n), .rd_cs_n(rd_cs_n), .mark(mark), .rexmit(rexmit),
    .rd_data(rd_data), .rd_flag(rd_flag), .full(full)
  );

  // {wr, rd, wdata[7:0], exp_flag, exp_full, exp_rdata[7:0]}; rdata checked when rd=1
  localparam logic [19:0] VEC [8] = '{
    {1'b1, 1'b0, 8'h11, 1'b1, 1'b0, 8'h00},
    {1'b1, 1'b0, 8'h22, 1'b1, 1'b0, 8'h00},
    {1'b1, 1'b1, 8'h33, 1'b1, 1'b0, 8'h11},
    {1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 8'h22},
    {1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 8'h33},
    {1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 8'h33},
    {1'b1, 1'b0, 8'h44, 1'b1, 1'b0, 8'h00},
    {1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 8'h44}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic style);
    fwft_sel = style;
    rst = 1'b1;
    wr_en_n = 1'b1; rd_en_n = 1'b1; wr_cs_n = 1'b0; rd_cs_n = 1'b0;
    mark = 1'b0; rexmit = 1'b0;
    repeat (2) @(posedge clk);
    #2 rst = 1'b0;
  endtask

  task automatic cyc(input logic w, input logic r, input logic [DW-1:0] d,
                     input logic mk = 1'b0, input logic rx = 1'b0);
    wr_en_n = ~w; rd_en_n = ~r; wr_data = d; mark = mk; rexmit = rx;
    @(posedge clk);
    #2;
    wr_en_n = 1'b1; rd_en_n = 1'b1; mark = 1'b0; rexmit = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    // R11: reset state, standard style
    do_reset(1'b0);
    chk("R11 std flag after reset", rd_flag, 0);
    chk("R11 full after reset", full, 0);

    // R1 R3 R4: vector table walk
    foreach (VEC[i]) begin
      cyc(VEC[i][19], VEC[i][18], VEC[i][17:10]);
      chk($sformatf("R3 vec%0d flag", i), rd_flag, VEC[i][9]);
      chk($sformatf("R1 vec%0d full", i), full, VEC[i][8]);
      if (VEC[i][18]) chk($sformatf("R4 vec%0d rdata", i), rd_data, VEC[i][7:0]);
    end

    // R2: fill to capacity, extra write dropped
    do_reset(1'b0);
    for (int i = 0; i < DEPTH; i++) cyc(1'b1, 1'b0, 8'hA0 + 8'(i));
    chk("R2 full at capacity", full, 1);
    cyc(1'b1, 1'b0, 8'hEE);
    chk("R2 full after dropped write", full, 1);
    for (int i = 0; i < DEPTH; i++) begin
      cyc(1'b0, 1'b1, 8'h00);
      chk("R2 drain order", rd_data, 8'hA0 + 8'(i));
    end
    chk("R2 empty after drain (extra word dropped)", rd_flag, 0);
    chk("R2 not full after drain", full, 0);
    // R8 R9: rewind recomputes level
    cyc(1'b0, 1'b0, 8'h00, 1'b0, 1'b1);
    chk("R8 std flag low after rewind", rd_flag, 0);
    chk("R9 full recomputed after rewind", full, 1);
    cyc(1'b0, 1'b0, 8'h00);
    chk("R8 std flag back after one cycle", rd_flag, 1);
    cyc(1'b0, 1'b1, 8'h00);
    chk("R6 first word after rewind", rd_data, 8'hA0);

    // R1 R5: select gating
    do_reset(1'b0);
    wr_cs_n = 1'b1;
    cyc(1'b1, 1'b0, 8'h33);
    chk("R1 write blocked by select", rd_flag, 0);
    wr_cs_n = 1'b0;
    cyc(1'b1, 1'b0, 8'h5A);
    rd_cs_n = 1'b1;
    cyc(1'b0, 1'b1, 8'h00);
    chk("R5 read blocked by select", rd_flag, 1);
    rd_cs_n = 1'b0;
    cyc(1'b0, 1'b1, 8'h00);
    chk("R5 read after select", rd_data, 8'h5A);
    chk("R5 empty after read", rd_flag, 0);

    // R6 R9: rewind to first, write side untouched
    do_reset(1'b0);
    cyc(1'b1, 1'b0, 8'h10);
    cyc(1'b1, 1'b0, 8'h20);
    cyc(1'b1, 1'b0, 8'h30);
    cyc(1'b0, 1'b1, 8'h00);
    cyc(1'b0, 1'b1, 8'h00);
    chk("R3 second read", rd_data, 8'h20);
    cyc(1'b0, 1'b0, 8'h00, 1'b0, 1'b1);
    chk("R8 flag low on rewind", rd_flag, 0);
    cyc(1'b0, 1'b0, 8'h00);
    cyc(1'b0, 1'b1, 8'h00);
    chk("R6 rewind to first word", rd_data, 8'h10);
    cyc(1'b0, 1'b1, 8'h00);
    cyc(1'b0, 1'b1, 8'h00);
    chk("R9 last word still present", rd_data, 8'h30);
    chk("R9 empty after last word", rd_flag, 0);

    // R7: rewind to mark, standard style
    do_reset(1'b0);
    for (int i = 0; i < 4; i++) cyc(1'b1, 1'b0, 8'h61 + 8'(i));
    cyc(1'b0, 1'b1, 8'h00);
    cyc(1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
    cyc(1'b0, 1'b1, 8'h00);
    cyc(1'b0, 1'b1, 8'h00);
    chk("R3 read before rewind", rd_data, 8'h63);
    cyc(1'b0, 1'b0, 8'h00, 1'b0, 1'b1);
    cyc(1'b0, 1'b0, 8'h00);
    cyc(1'b0, 1'b1, 8'h00);
    chk("R7 rewind to marked word", rd_data, 8'h62);

    // R10 R11 R8 R7: fall-through style
    do_reset(1'b1);
    chk("R11 fwft flag after reset", rd_flag, 1);
    cyc(1'b1, 1'b0, 8'h71);
    chk("R10 not ready on write edge", rd_flag, 1);
    cyc(1'b1, 1'b0, 8'h72);
    chk("R10 ready one cycle later", rd_flag, 0);
    chk("R10 head word shown", rd_data, 8'h71);
    cyc(1'b0, 1'b1, 8'h00);
    chk("R10 read advances", rd_data, 8'h72);
    cyc(1'b0, 1'b1, 8'h00);
    chk("R10 not ready when drained", rd_flag, 1);
    cyc(1'b0, 1'b0, 8'h00, 1'b0, 1'b1);
    chk("R8 fwft not ready after rewind", rd_flag, 1);
    cyc(1'b0, 1'b0, 8'h00);
    chk("R8 fwft ready after refill", rd_flag, 0);
    chk("R6 fwft first word", rd_data, 8'h71);
    cyc(1'b0, 1'b1, 8'h00);
    cyc(1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
    cyc(1'b0, 1'b1, 8'h00);
    chk("R10 drained again", rd_flag, 1);
    cyc(1'b0, 1'b0, 8'h00, 1'b0, 1'b1);
    cyc(1'b0, 1'b0, 8'h00);
    chk("R7 fwft mark is shown word", rd_data, 8'h72);
    chk("R7 fwft ready at mark", rd_flag, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule